// File: doc/BRIEF.md
# Fully associative translation lookaside buffer

This block keeps a small set of recently used page translations and turns the virtual page number of a 32-bit virtual address into a physical frame number in a single cycle. Every stored entry is compared at the same time. The 12-bit offset inside the 4 KB page passes through unchanged. The physical address is the frame number placed above that offset, so no adder is involved. Each lookup also carries an access kind (read, write or execute). The entry's permission field is checked against that kind, so a lookup ends in one of four ways: a translation, a miss, a page fault or a protection fault.

Each entry has two flags that are kept apart. The slot-live flag says that the slot holds a translation at all. It is used for matching and is cleared by the flush input. The resident flag is the page-table valid bit that came with the refill. It tells a page that is mapped but not in memory apart from a page that is not cached here. When an access is granted, the entry's reference bit is set, and a granted write also sets its dirty bit. Both bits are shown on the lookup outputs. A refill port, driven by an outside page-table walker after a miss, writes one entry per cycle.

Top module: `tlb_assoc`

## Requirements
- R1: After reset, and in every cycle after a cycle with `flushAll` high, no slot is live, so every lookup reports a miss with no fault.
- R2: A lookup whose page number matches a live, resident entry that permits the access kind raises `hit` and outputs `physAddr` = {entry frame, low 12 address bits}. All lookup outputs follow the inputs in the same cycle.
- R3: A lookup that matches no live entry raises `miss` and keeps `hit`, `pageFault` and `protFault` low, with `physAddr` zero.
- R4: A hit on an entry whose resident flag is 0 raises `pageFault` for every access kind, keeps `protFault` low and drives `physAddr` to zero.
- R5: Kind codes are read 00, write 01, execute 10 and reserved 11. Rights codes are read-only 00, read/write 01, execute-only 10 and no-access 11. A read is permitted by 00 or 01, a write only by 01, an execute only by 10, and the reserved kind by nothing. A resident hit that is not permitted raises `protFault`.
- R6: A protection fault drives `physAddr` to zero and leaves the entry's reference and dirty bits unchanged.
- R7: A granted access sets the entry's reference bit, and `hitRef` shows the bit as it was before the current lookup. A refill clears the reference bit.
- R8: A granted write sets the entry's dirty bit, and `hitDirty` shows the bit as it was before the current lookup. A refill clears the dirty bit.
- R9: A refill goes, in order of preference, into the live entry with the same page number, then into the lowest-numbered free slot, then into the slot named by a victim pointer. The pointer starts at 0 and steps by one, modulo the entry count, only when it is used. At most one entry ever matches a page number.
- R10: `flushAll` clears every slot in one cycle, and a refill in the same cycle is discarded.
- R11: With `lookupValid` low, `hit`, `miss`, both faults and `physAddr` are zero. With it high, exactly one of `hit` and `miss` is high. A refill becomes visible to lookups from the next cycle, so a lookup in the refill cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupVa | input | 32 | Virtual address to translate |
| lookupKind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| hit | output | 1 | A live entry matches the page number |
| miss | output | 1 | No live entry matches |
| pageFault | output | 1 | Matching entry is not resident |
| protFault | output | 1 | Matching resident entry does not permit the access |
| physAddr | output | 32 | Translated address, zero unless the access is granted |
| hitDirty | output | 1 | Dirty bit of the matching entry before this lookup |
| hitRef | output | 1 | Reference bit of the matching entry before this lookup |
| refillValid | input | 1 | Write one entry at the next edge |
| refillVpn | input | 20 | Virtual page number of the new entry |
| refillPfn | input | 20 | Physical frame number of the new entry |
| refillRights | input | 2 | Rights code of the new entry |
| refillResident | input | 1 | Page present in memory |
| flushAll | input | 1 | Clear every slot at the next edge |

## Verification
Lookup results are combinational and due in the cycle the lookup is presented. The bench drives each lookup at a falling edge and samples all outputs 1 ns later, before the next rising edge. Reference and dirty updates, refills and flushes take effect at the next rising edge. The bench therefore checks them with a lookup presented at the following falling edge. For the same-cycle case it samples before that edge, so the old contents are expected. A bench model follows every slot, so that the placement order and the victim pointer give exact expected slots.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int IDX_MAX_W = 8;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_EXEC  = 2'b10,
    KIND_RSVD  = 2'b11
  } accessKind_e;

  typedef enum logic [1:0] {
    RIGHT_RO   = 2'b00,
    RIGHT_RW   = 2'b01,
    RIGHT_XO   = 2'b10,
    RIGHT_NONE = 2'b11
  } accessRights_e;

  typedef struct packed {
    logic                 wr;
    logic [IDX_MAX_W-1:0] wrIdx;
    logic                 upd;
    logic [IDX_MAX_W-1:0] updIdx;
    logic                 setDirty;
    logic                 flush;
  } tlbStrobe_t;

  function automatic logic rightsAllow(logic [1:0] rights, logic [1:0] kind);
    return (kind == KIND_READ  && (rights == RIGHT_RO || rights == RIGHT_RW)) ||
           (kind == KIND_WRITE && rights == RIGHT_RW) ||
           (kind == KIND_EXEC  && rights == RIGHT_XO);
  endfunction

endpackage

// File: rtl/tlb_assoc_data.sv
module tlb_assoc_data
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobe_t         strobe,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic [VPN_W-1:0]   refillVpn,
  input  logic [PFN_W-1:0]   refillPfn,
  input  logic [1:0]         refillRights,
  input  logic               refillResident,
  output logic [ENTRIES-1:0] lookMatch,
  output logic [ENTRIES-1:0] refillMatch,
  output logic [ENTRIES-1:0] liveVec,
  output logic [PFN_W-1:0]   selPfn,
  output logic [1:0]         selRights,
  output logic               selResident,
  output logic               selDirty,
  output logic               selRef
);

  logic [ENTRIES-1:0][PFN_W-1:0] pfnMask;
  logic [ENTRIES-1:0][1:0]       rightsMask;
  logic [ENTRIES-1:0][2:0]       flagMask;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic             liveQ, residentQ, dirtyQ, refQ;
    logic [VPN_W-1:0] tagQ;
    logic [PFN_W-1:0] pfnQ;
    logic [1:0]       rightsQ;
    logic             wrHere, updHere;

    assign wrHere  = strobe.wr  && (strobe.wrIdx  == IDX_MAX_W'(i));
    assign updHere = strobe.upd && (strobe.updIdx == IDX_MAX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             liveQ <= 1'b0;
      else if (strobe.flush) liveQ <= 1'b0;
      else if (wrHere)       liveQ <= 1'b1;
    end

    // Refill takes priority over a reference/dirty update of the same slot.
    always_ff @(posedge clk) begin
      if (wrHere) begin
        tagQ      <= refillVpn;
        pfnQ      <= refillPfn;
        rightsQ   <= refillRights;
        residentQ <= refillResident;
        dirtyQ    <= 1'b0;
        refQ      <= 1'b0;
      end else if (updHere) begin
        refQ <= 1'b1;
        if (strobe.setDirty) dirtyQ <= 1'b1;
      end
    end

    assign lookMatch[i]   = liveQ && (tagQ == lookupVpn);
    assign refillMatch[i] = liveQ && (tagQ == refillVpn);
    assign liveVec[i]     = liveQ;
    assign pfnMask[i]     = lookMatch[i] ? pfnQ : '0;
    assign rightsMask[i]  = lookMatch[i] ? rightsQ : '0;
    assign flagMask[i]    = lookMatch[i] ? {residentQ, dirtyQ, refQ} : '0;
  end

  // AND-OR read mux: at most one match line is high.
  always_comb begin
    logic [2:0] flags;
    selPfn    = '0;
    selRights = '0;
    flags     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      selPfn    = selPfn    | pfnMask[i];
      selRights = selRights | rightsMask[i];
      flags     = flags     | flagMask[i];
    end
    {selResident, selDirty, selRef} = flags;
  end

endmodule

// File: rtl/tlb_assoc_ctrl.sv
module tlb_assoc_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic [1:0]         lookupKind,
  input  logic [ENTRIES-1:0] lookMatch,
  input  logic               refillValid,
  input  logic [ENTRIES-1:0] refillMatch,
  input  logic [ENTRIES-1:0] liveVec,
  input  logic               flushAll,
  input  logic [1:0]         selRights,
  input  logic               selResident,
  output logic               hit,
  output logic               miss,
  output logic               pageFault,
  output logic               protFault,
  output logic               grant,
  output tlbStrobe_t         strobe
);

  logic [IDX_MAX_W-1:0] ptrQ;
  logic                 anyHit, anyRefillMatch, allLive, usePtr;
  logic [IDX_MAX_W-1:0] hitIdx, matchIdx, freeIdx, slotIdx;

  function automatic logic [IDX_MAX_W-1:0] encodeOneHot(logic [ENTRIES-1:0] vec);
    logic [IDX_MAX_W-1:0] idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (vec[i]) idx = idx | IDX_MAX_W'(i);
    return idx;
  endfunction

  function automatic logic [IDX_MAX_W-1:0] lowestFree(logic [ENTRIES-1:0] live);
    logic [IDX_MAX_W-1:0] idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!live[i]) idx = IDX_MAX_W'(i);
    return idx;
  endfunction

  assign anyHit         = |lookMatch;
  assign anyRefillMatch = |refillMatch;
  assign allLive        = &liveVec;

  assign hit       = lookupValid && anyHit;
  assign miss      = lookupValid && !anyHit;
  assign pageFault = hit && !selResident;
  assign protFault = hit && selResident && !rightsAllow(selRights, lookupKind);
  assign grant     = hit && selResident && rightsAllow(selRights, lookupKind);

  assign hitIdx   = encodeOneHot(lookMatch);
  assign matchIdx = encodeOneHot(refillMatch);
  assign freeIdx  = lowestFree(liveVec);
  assign usePtr   = !anyRefillMatch && allLive;
  assign slotIdx  = anyRefillMatch ? matchIdx : (allLive ? ptrQ : freeIdx);

  always_comb begin
    strobe          = '0;
    strobe.wr       = refillValid && !flushAll;
    strobe.wrIdx    = slotIdx;
    strobe.upd      = grant;
    strobe.updIdx   = hitIdx;
    strobe.setDirty = (lookupKind == KIND_WRITE);
    strobe.flush    = flushAll;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptrQ <= '0;
    else if (refillValid && !flushAll && usePtr)
      ptrQ <= (ptrQ == IDX_MAX_W'(ENTRIES - 1)) ? '0 : ptrQ + 1'b1;
  end

endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      lookupValid,
  input  logic [VA_W-1:0]           lookupVa,
  input  logic [1:0]                lookupKind,
  output logic                      hit,
  output logic                      miss,
  output logic                      pageFault,
  output logic                      protFault,
  output logic [PA_W-1:0]           physAddr,
  output logic                      hitDirty,
  output logic                      hitRef,
  input  logic                      refillValid,
  input  logic [VA_W-PAGE_BITS-1:0] refillVpn,
  input  logic [PA_W-PAGE_BITS-1:0] refillPfn,
  input  logic [1:0]                refillRights,
  input  logic                      refillResident,
  input  logic                      flushAll
);

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PFN_W = PA_W - PAGE_BITS;

  tlbStrobe_t         strobe;
  logic [ENTRIES-1:0] lookMatch, refillMatch, liveVec;
  logic [PFN_W-1:0]   selPfn;
  logic [1:0]         selRights;
  logic               selResident, selDirty, selRef, grant;

  tlb_assoc_data #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lookupVpn(lookupVa[VA_W-1:PAGE_BITS]), .refillVpn(refillVpn),
    .refillPfn(refillPfn), .refillRights(refillRights), .refillResident(refillResident),
    .lookMatch(lookMatch), .refillMatch(refillMatch), .liveVec(liveVec),
    .selPfn(selPfn), .selRights(selRights), .selResident(selResident),
    .selDirty(selDirty), .selRef(selRef)
  );

  tlb_assoc_ctrl #(.ENTRIES(ENTRIES)) i_ctrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupKind(lookupKind),
    .lookMatch(lookMatch), .refillValid(refillValid), .refillMatch(refillMatch),
    .liveVec(liveVec), .flushAll(flushAll), .selRights(selRights),
    .selResident(selResident), .hit(hit), .miss(miss), .pageFault(pageFault),
    .protFault(protFault), .grant(grant), .strobe(strobe)
  );

  assign physAddr = grant ? {selPfn, lookupVa[PAGE_BITS-1:0]} : '0;
  assign hitDirty = hit && selDirty;
  assign hitRef   = hit && selRef;

endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               lookupValid,
  input logic [VA_W-1:0]    lookupVa,
  input logic               hit,
  input logic               miss,
  input logic               pageFault,
  input logic               protFault,
  input logic [PA_W-1:0]    physAddr,
  input logic               flushAll,
  input logic [ENTRIES-1:0] lookMatch
);

  a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> (lookMatch == '0));

  a_r2_offset_passes: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !pageFault && !protFault) |->
      (physAddr[PAGE_BITS-1:0] == lookupVa[PAGE_BITS-1:0]));

  a_r3_miss_quiet: assert property (@(posedge clk) disable iff (!rstN)
    miss |-> (!pageFault && !protFault && physAddr == '0));

  a_r4_page_fault_alone: assert property (@(posedge clk) disable iff (!rstN)
    pageFault |-> (hit && !protFault && physAddr == '0));

  a_r6_prot_no_address: assert property (@(posedge clk) disable iff (!rstN)
    protFault |-> (hit && physAddr == '0));

  a_r9_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookMatch));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> (!hit && !miss && physAddr == '0));

  a_r11_hit_or_miss: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |-> (hit != miss));

endmodule

bind tlb_assoc tlb_assoc_chk #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVa(lookupVa),
  .hit(hit), .miss(miss), .pageFault(pageFault), .protFault(protFault),
  .physAddr(physAddr), .flushAll(flushAll), .lookMatch(lookMatch)
);

// File: tb/test_tlb_assoc.sv
module test_tlb_assoc;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupVa = '0;
  logic [1:0]  lookupKind = '0;
  logic        hit, miss, pageFault, protFault, hitDirty, hitRef;
  logic [31:0] physAddr;
  logic        refillValid = 1'b0;
  logic [19:0] refillVpn = '0;
  logic [19:0] refillPfn = '0;
  logic [1:0]  refillRights = '0;
  logic        refillResident = 1'b0;
  logic        flushAll = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [19:0] mVpn [N];
  logic [19:0] mPfn [N];
  logic [1:0]  mRights [N];
  logic        mRes [N], mLive [N], mRef [N], mDirty [N];
  int          mPtr = 0;

  tlb_assoc i_tlb_assoc (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVa(lookupVa),
    .lookupKind(lookupKind), .hit(hit), .miss(miss), .pageFault(pageFault),
    .protFault(protFault), .physAddr(physAddr), .hitDirty(hitDirty), .hitRef(hitRef),
    .refillValid(refillValid), .refillVpn(refillVpn), .refillPfn(refillPfn),
    .refillRights(refillRights), .refillResident(refillResident), .flushAll(flushAll)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, string ph, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s (phase %s): actual=%0h expected=%0h", req, what, ph, act, exp);
    end
  endtask

  // Rights table of R5, written from the requirement.
  function automatic bit allowed(logic [1:0] rt, logic [1:0] kind);
    case (kind)
      2'b00:   return (rt == 2'b00) || (rt == 2'b01);
      2'b01:   return rt == 2'b01;
      2'b10:   return rt == 2'b10;
      default: return 1'b0;
    endcase
  endfunction

  task automatic modelRefill(logic [19:0] vpn, logic [19:0] pfn, logic [1:0] rt, logic res);
    int slot = -1;
    for (int s = 0; s < N; s++) if (mLive[s] && mVpn[s] == vpn) slot = s;
    if (slot < 0) for (int s = N - 1; s >= 0; s--) if (!mLive[s]) slot = s;
    if (slot < 0) begin
      slot = mPtr;
      mPtr = (mPtr + 1) % N;
    end
    mVpn[slot] = vpn; mPfn[slot] = pfn; mRights[slot] = rt; mRes[slot] = res;
    mLive[slot] = 1'b1; mRef[slot] = 1'b0; mDirty[slot] = 1'b0;
  endtask

  // Compare the combinational lookup outputs with the model; returns grant slot or -1.
  task automatic expectLookup(string ph, logic [19:0] vpn, logic [11:0] off, logic [1:0] kind,
                              output int grantSlot);
    int  s = -1;
    bit  eHit, ePf, eProt, eGrant;
    logic [31:0] ePa;
    for (int k = 0; k < N; k++) if (mLive[k] && mVpn[k] == vpn) s = k;
    eHit   = (s >= 0);
    ePf    = eHit && !mRes[s];
    eProt  = eHit && mRes[s] && !allowed(mRights[s], kind);
    eGrant = eHit && mRes[s] && allowed(mRights[s], kind);
    ePa    = eGrant ? {mPfn[s], off} : 32'h0;
    chk("R2", ph, "hit", 64'(hit), 64'(eHit));
    chk("R3", ph, "miss", 64'(miss), 64'(!eHit));
    chk("R4", ph, "pageFault", 64'(pageFault), 64'(ePf));
    chk("R5", ph, "protFault", 64'(protFault), 64'(eProt));
    chk("R2", ph, "physAddr", 64'(physAddr), 64'(ePa));
    chk("R7", ph, "hitRef", 64'(hitRef), 64'(eHit && mRef[s]));
    chk("R8", ph, "hitDirty", 64'(hitDirty), 64'(eHit && mDirty[s]));
    grantSlot = eGrant ? s : -1;
  endtask

  task automatic idleInputs();
    lookupValid = 1'b0; refillValid = 1'b0; flushAll = 1'b0;
  endtask

  task automatic doLookup(string ph, logic [19:0] vpn, logic [11:0] off, logic [1:0] kind);
    int g;
    @(negedge clk);
    idleInputs();
    lookupValid = 1'b1; lookupVa = {vpn, off}; lookupKind = kind;
    #1;
    expectLookup(ph, vpn, off, kind, g);
    if (g >= 0) begin
      mRef[g] = 1'b1;
      if (kind == 2'b01) mDirty[g] = 1'b1;
    end
  endtask

  task automatic doRefill(logic [19:0] vpn, logic [19:0] pfn, logic [1:0] rt, logic res);
    @(negedge clk);
    idleInputs();
    refillValid = 1'b1; refillVpn = vpn; refillPfn = pfn;
    refillRights = rt; refillResident = res;
    modelRefill(vpn, pfn, rt, res);
  endtask

  // R11: lookup of the page being refilled in the same cycle sees old contents.
  task automatic refillWithLookup(logic [19:0] vpn, logic [19:0] pfn);
    int g;
    @(negedge clk);
    idleInputs();
    refillValid = 1'b1; refillVpn = vpn; refillPfn = pfn;
    refillRights = 2'b01; refillResident = 1'b1;
    lookupValid = 1'b1; lookupVa = {vpn, 12'h5a5}; lookupKind = 2'b00;
    #1;
    chk("R11", "same-cycle", "miss", 64'(miss), 64'd1);
    expectLookup("R11", vpn, 12'h5a5, 2'b00, g);
    modelRefill(vpn, pfn, 2'b01, 1'b1);
  endtask

  task automatic doFlush(bit withRefill, logic [19:0] vpn);
    @(negedge clk);
    idleInputs();
    flushAll = 1'b1;
    refillValid = withRefill; refillVpn = vpn; refillPfn = 20'h12345;
    refillRights = 2'b01; refillResident = 1'b1;
    for (int s = 0; s < N; s++) mLive[s] = 1'b0;
  endtask

  function automatic logic [19:0] slotVpn(int k);
    return 20'h10000 + 20'(k * 32'h111);
  endfunction

  initial begin
    logic [1:0] kinds [4] = '{2'b10, 2'b11, 2'b01, 2'b00};
    for (int s = 0; s < N; s++) begin
      mLive[s] = 1'b0; mRef[s] = 1'b0; mDirty[s] = 1'b0;
      mVpn[s] = '0; mPfn[s] = '0; mRights[s] = '0; mRes[s] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 and R11: reset state, idle outputs and misses.
    @(negedge clk);
    idleInputs();
    lookupVa = 32'h10000123;
    #1;
    chk("R11", "idle", "hit|miss|faults", 64'({hit, miss, pageFault, protFault}), 64'd0);
    chk("R11", "idle", "physAddr", 64'(physAddr), 64'd0);
    for (int k = 0; k < 3; k++) begin
      doLookup("R1", slotVpn(k), 12'h010, 2'(k));
      chk("R1", "reset", "miss", 64'(miss), 64'd1);
    end

    // R9: fill the free slots in order.
    for (int k = 0; k < N; k++)
      doRefill(slotVpn(k), 20'hA0000 ^ 20'(k * 32'h1357), 2'(k % 4), (k % 3) != 2);

    // R5, R4, R6, R7, R8: sweep every entry with every kind, faults first.
    for (int k = 0; k < N; k++)
      for (int j = 0; j < 4; j++)
        doLookup("R6", slotVpn(k), 12'((k * 32'h2c5 + j * 32'h41) & 32'hfff), kinds[j]);
    for (int k = 0; k < N; k++)
      doLookup("R7", slotVpn(k), 12'(k * 32'h31), 2'b00);

    // R3: pages never loaded.
    for (int j = 0; j < 4; j++) doLookup("R3", 20'h00042 + 20'(j), 12'hfff, 2'(j));

    // R11: same-cycle refill is not yet visible; victim slot 0 is used.
    refillWithLookup(20'h20001, 20'h0BEEF);
    doLookup("R11", 20'h20001, 12'h5a5, 2'b00);
    doLookup("R9", slotVpn(0), 12'h000, 2'b00);

    // R9: round-robin victims, then overwrite of an existing page.
    doRefill(20'h20002, 20'h0C001, 2'b00, 1'b1);
    doRefill(20'h20003, 20'h0C002, 2'b10, 1'b1);
    doLookup("R9", slotVpn(1), 12'h001, 2'b00);
    doLookup("R9", slotVpn(2), 12'h002, 2'b00);
    doLookup("R9", 20'h20002, 12'h003, 2'b00);
    doLookup("R9", 20'h20003, 12'h004, 2'b10);
    doLookup("R8", slotVpn(5), 12'h111, 2'b01);
    doRefill(slotVpn(5), 20'h0D005, 2'b01, 1'b1);
    doLookup("R7", slotVpn(5), 12'h222, 2'b00);
    doRefill(20'h20004, 20'h0C003, 2'b01, 1'b1);
    doLookup("R9", slotVpn(3), 12'h333, 2'b00);
    doLookup("R9", slotVpn(4), 12'h444, 2'b00);
    doLookup("R9", 20'h20004, 12'h555, 2'b01);
    doLookup("R8", 20'h20004, 12'h556, 2'b00);

    // R10: flush wins over a refill in the same cycle.
    doFlush(1'b1, 20'h30000);
    doLookup("R10", 20'h30000, 12'h010, 2'b00);
    doLookup("R10", 20'h20001, 12'h010, 2'b00);
    doLookup("R10", slotVpn(7), 12'h010, 2'b00);
    doRefill(20'h40000, 20'h0E000, 2'b01, 1'b1);
    doRefill(20'h40001, 20'h0E001, 2'b10, 1'b0);
    doLookup("R10", 20'h40000, 12'h7ff, 2'b01);
    doLookup("R10", 20'h40001, 12'h7ff, 2'b10);

    // R1: plain flush leaves nothing live.
    doFlush(1'b0, 20'h0);
    doLookup("R1", 20'h40000, 12'h001, 2'b00);
    doLookup("R1", 20'h40001, 12'h001, 2'b10);
    chk("R1", "flush", "miss", 64'(miss), 64'd1);

    @(negedge clk);
    idleInputs();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule